// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the 8-bit datapath core of a small accumulator machine. It holds the accumulator, a five-bit status flag register and a 16-bit register-pair result. On every clock edge with `op_en` high it runs one operation. The operation comes from a 3-bit kind code and, for the two-operand group, from a 3-bit operation field. It then writes the new accumulator and flags. Each operation has its own rule for the flags: some flags are recomputed, some are forced low, and some are left alone.

The two-operand group covers add, add with carry, subtract, subtract with borrow, AND, XOR, OR and compare. The accumulator is the first operand and `opnd_b` is the second, whether that byte came from a register, memory or an immediate. The other kinds are: increment and decrement of the accumulator, complement of the accumulator, complement of carry, a decimal adjust that corrects the accumulator to packed BCD after an addition, a 16-bit pair add, and a plain accumulator load. Fetch, addressing and the register file live outside the block.

Top module: `accum_alu`

## Requirements
- R1: While `rst_n` is low, and after it rises, `acc_o`, `flags_o` and `pair_o` are all zero until the first enabled operation.
- R2: With `op_kind`=0, `op_field` selects the operation: 0 add, 1 add with carry (A+B+CY), 2 subtract, 3 subtract with borrow (A-B-CY), 4 AND, 5 XOR, 6 OR, 7 compare. The outputs show the result one clock edge after the operation is applied. `flags_o` is {S,Z,AC,P,CY} from bit 4 down to bit 0.
- R3: Whenever an operation recomputes them, S equals bit 7 of the result, Z is 1 exactly when the result is 0x00, and P is 1 when the result has an even number of one bits.
- R4: For add and add with carry, CY is the carry out of bit 7 and AC is the carry out of bit 3. For subtract, subtract with borrow and compare, CY is 1 on a borrow out of bit 7 and AC is 1 on a borrow out of bit 3.
- R5: Compare computes A-B, sets all five flags as subtract does, and leaves `acc_o` unchanged.
- R6: AND sets S, Z and P from the result, sets AC to bit 3 of the accumulator OR bit 3 of the operand, and forces CY to 0.
- R7: XOR and OR set S, Z and P from the result and force both AC and CY to 0.
- R8: `op_kind`=1 increments the accumulator and `op_kind`=2 decrements it. Both set S, Z and P from the result and keep CY. For increment, AC=1 when the old low nibble was 0xF. For decrement, AC=1 when the old low nibble was 0x0.
- R9: `op_kind`=3 inverts the accumulator and changes no flag. `op_kind`=4 inverts CY and changes nothing else.
- R10: `op_kind`=5 is the decimal adjust, done in two steps. First, 0x06 is added when the low nibble is above 9 or AC is set, and AC becomes the carry out of bit 3 of that first addition. Second, 0x60 is added when CY is set, when the first step carried out of bit 7, or when the high nibble after the first step is above 9. CY ends equal to whether the second correction happened. S, Z and P come from the final value.
- R11: `op_kind`=6 writes `pair_a`+`pair_b` (modulo 2^16) to `pair_o` and the carry out of bit 15 to CY. S, Z, AC, P and the accumulator are unchanged.
- R12: `op_kind`=7 copies `opnd_b` into the accumulator and leaves all flags unchanged.
- R13: With `op_en` low, the accumulator, flags and pair result keep their values whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| op_en | input | 1 | Apply the presented operation at this edge |
| op_kind | input | 3 | Operation kind (0 group, 1 inc, 2 dec, 3 complement A, 4 complement CY, 5 decimal adjust, 6 pair add, 7 load) |
| op_field | input | 3 | Two-operand operation select used when `op_kind` is 0 |
| opnd_b | input | 8 | Second byte operand |
| pair_a | input | 16 | First 16-bit addend |
| pair_b | input | 16 | Second 16-bit addend |
| acc_o | output | 8 | Accumulator |
| flags_o | output | 5 | Flags {S,Z,AC,P,CY} |
| pair_o | output | 16 | Last 16-bit pair sum |

## Verification
The bench pushes subtract with borrow and add with carry through nibble and byte boundaries with CY both set and clear. A wrong carry-in polarity or a wrong borrow sense shows up as a result off by one, or as an inverted CY or AC. It runs decimal-adjust cases in which the low correction ripples into the high nibble or wraps past 0xFF. A design that tests the high nibble before the low correction, or drops the wrap carry, gives a wrong BCD byte or a clear CY. It also checks the flag-preservation corners, where a careless design would disturb state the operation must not touch: compare with equal operands, carry surviving increment and decrement, the pair add touching only CY, and idle cycles with noisy inputs.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

  localparam int ALU_W  = 8;
  localparam int NIB_W  = ALU_W / 2;
  localparam int PAIR_W = 2 * ALU_W;
  localparam logic [NIB_W-1:0] BCD_MAX = NIB_W'(9);
  localparam logic [ALU_W-1:0] LO_ADJ  = ALU_W'(6);
  localparam logic [ALU_W-1:0] HI_ADJ  = ALU_W'(8'h60);

  typedef enum logic [2:0] {
    K_GROUP = 3'd0,
    K_INC   = 3'd1,
    K_DEC   = 3'd2,
    K_CPLA  = 3'd3,
    K_CPLC  = 3'd4,
    K_DADJ  = 3'd5,
    K_WIDE  = 3'd6,
    K_LOAD  = 3'd7
  } op_kind_e;

  typedef enum logic [2:0] {
    F_ADD = 3'd0,
    F_ADC = 3'd1,
    F_SUB = 3'd2,
    F_SBB = 3'd3,
    F_AND = 3'd4,
    F_XOR = 3'd5,
    F_OR  = 3'd6,
    F_CMP = 3'd7
  } op_field_e;

  typedef struct packed {
    logic s;
    logic z;
    logic ac;
    logic p;
    logic cy;
  } flags_t;

  function automatic logic even_ones(input logic [ALU_W-1:0] v);
    return ~^v;
  endfunction

  function automatic flags_t result_flags(input logic [ALU_W-1:0] r,
                                          input logic ac, input logic cy);
    flags_t f;
    f.s  = r[ALU_W-1];
    f.z  = (r == '0);
    f.ac = ac;
    f.p  = even_ones(r);
    f.cy = cy;
    return f;
  endfunction

  function automatic logic [ALU_W:0] add_ext(input logic [ALU_W-1:0] a,
                                             input logic [ALU_W-1:0] b,
                                             input logic ci);
    return {1'b0, a} + {1'b0, b} + {{ALU_W{1'b0}}, ci};
  endfunction

  function automatic logic nib_carry(input logic [ALU_W-1:0] a,
                                     input logic [ALU_W-1:0] b,
                                     input logic ci);
    logic [NIB_W:0] t;
    t = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]} + {{NIB_W{1'b0}}, ci};
    return t[NIB_W];
  endfunction

endpackage

// File: rtl/accum_alu_group.sv
module accum_alu_group
  import accum_alu_pkg::*;
(
  input  op_field_e        field,
  input  logic [ALU_W-1:0] acc,
  input  logic [ALU_W-1:0] opnd,
  input  flags_t           fin,
  output logic [ALU_W-1:0] res,
  output flags_t           fout,
  output logic             acc_we
);

  logic             sub_mode;
  logic             use_cy;
  logic [ALU_W-1:0] b_eff;
  logic             cin_eff;
  logic [ALU_W:0]   sum;
  logic             low_carry;
  logic             arith_cy;
  logic             arith_ac;

  // Subtraction is done as A + ~B + ~borrow_in; carries become inverted borrows.
  always_comb begin
    sub_mode  = (field == F_SUB) || (field == F_SBB) || (field == F_CMP);
    use_cy    = (field == F_ADC) || (field == F_SBB);
    b_eff     = sub_mode ? ~opnd : opnd;
    cin_eff   = sub_mode ? ~(use_cy & fin.cy) : (use_cy & fin.cy);
    sum       = add_ext(acc, b_eff, cin_eff);
    low_carry = nib_carry(acc, b_eff, cin_eff);
    arith_cy  = sub_mode ? ~sum[ALU_W] : sum[ALU_W];
    arith_ac  = sub_mode ? ~low_carry  : low_carry;
  end

  always_comb begin
    res    = sum[ALU_W-1:0];
    fout   = result_flags(sum[ALU_W-1:0], arith_ac, arith_cy);
    acc_we = (field != F_CMP);
    unique case (field)
      F_AND: begin
        res  = acc & opnd;
        fout = result_flags(acc & opnd, acc[NIB_W-1] | opnd[NIB_W-1], 1'b0);
      end
      F_XOR: begin
        res  = acc ^ opnd;
        fout = result_flags(acc ^ opnd, 1'b0, 1'b0);
      end
      F_OR: begin
        res  = acc | opnd;
        fout = result_flags(acc | opnd, 1'b0, 1'b0);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/accum_alu_unary.sv
module accum_alu_unary
  import accum_alu_pkg::*;
(
  input  op_kind_e         kind,
  input  logic [ALU_W-1:0] acc,
  input  flags_t           fin,
  output logic [ALU_W-1:0] res,
  output flags_t           fout
);

  logic [ALU_W-1:0] inc_val;
  logic [ALU_W-1:0] dec_val;
  logic             low_fix;
  logic [ALU_W:0]   low_stage;
  logic             high_fix;
  logic [ALU_W-1:0] adj_val;

  always_comb begin
    inc_val   = acc + ALU_W'(1);
    dec_val   = acc - ALU_W'(1);
    low_fix   = (acc[NIB_W-1:0] > BCD_MAX) | fin.ac;
    low_stage = {1'b0, acc} + {1'b0, (low_fix ? LO_ADJ : '0)};
    high_fix  = fin.cy | low_stage[ALU_W]
              | (low_stage[ALU_W-1:NIB_W] > BCD_MAX);
    adj_val   = low_stage[ALU_W-1:0] + (high_fix ? HI_ADJ : '0);
  end

  always_comb begin
    res  = acc;
    fout = fin;
    unique case (kind)
      K_INC: begin
        res  = inc_val;
        fout = result_flags(inc_val, acc[NIB_W-1:0] == '1, fin.cy);
      end
      K_DEC: begin
        res  = dec_val;
        fout = result_flags(dec_val, acc[NIB_W-1:0] == '0, fin.cy);
      end
      K_CPLA: begin
        res = ~acc;
      end
      K_CPLC: begin
        fout.cy = ~fin.cy;
      end
      K_DADJ: begin
        res  = adj_val;
        fout = result_flags(adj_val, nib_carry(acc, low_fix ? LO_ADJ : '0, 1'b0),
                            high_fix);
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/accum_alu_wide.sv
module accum_alu_wide #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] sum,
  output logic             cout
);

  logic [WIDTH:0] full;

  always_comb begin
    full = {1'b0, a} + {1'b0, b};
    sum  = full[WIDTH-1:0];
    cout = full[WIDTH];
  end

endmodule

// File: rtl/accum_alu.sv
module accum_alu
  import accum_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  logic [2:0]        op_kind,
  input  logic [2:0]        op_field,
  input  logic [ALU_W-1:0]  opnd_b,
  input  logic [PAIR_W-1:0] pair_a,
  input  logic [PAIR_W-1:0] pair_b,
  output logic [ALU_W-1:0]  acc_o,
  output logic [4:0]        flags_o,
  output logic [PAIR_W-1:0] pair_o
);

  op_kind_e  kind_e;
  op_field_e field_e;

  logic [ALU_W-1:0]  acc_q;
  flags_t            flags_q;
  logic [PAIR_W-1:0] pair_q;

  logic [ALU_W-1:0]  grp_res;
  flags_t            grp_flags;
  logic              grp_writes_acc;
  logic [ALU_W-1:0]  un_res;
  flags_t            un_flags;
  logic [PAIR_W-1:0] wide_sum;
  logic              wide_carry;

  assign kind_e  = op_kind_e'(op_kind);
  assign field_e = op_field_e'(op_field);

  accum_alu_group u_group (
    .field  (field_e),
    .acc    (acc_q),
    .opnd   (opnd_b),
    .fin    (flags_q),
    .res    (grp_res),
    .fout   (grp_flags),
    .acc_we (grp_writes_acc)
  );

  accum_alu_unary u_unary (
    .kind (kind_e),
    .acc  (acc_q),
    .fin  (flags_q),
    .res  (un_res),
    .fout (un_flags)
  );

  accum_alu_wide #(.WIDTH(PAIR_W)) u_wide (
    .a    (pair_a),
    .b    (pair_b),
    .sum  (wide_sum),
    .cout (wide_carry)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      flags_q <= '0;
      pair_q  <= '0;
    end else if (op_en) begin
      unique case (kind_e)
        K_GROUP: begin
          flags_q <= grp_flags;
          if (grp_writes_acc) acc_q <= grp_res;
        end
        K_WIDE: begin
          pair_q     <= wide_sum;
          flags_q.cy <= wide_carry;
        end
        K_LOAD: acc_q <= opnd_b;
        default: begin
          acc_q   <= un_res;
          flags_q <= un_flags;
        end
      endcase
    end
  end

  assign acc_o   = acc_q;
  assign flags_o = flags_q;
  assign pair_o  = pair_q;

endmodule

// File: rtl/accum_alu_chk.sv
module accum_alu_chk
  import accum_alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              op_en,
  input logic [2:0]        op_kind,
  input logic [2:0]        op_field,
  input logic [ALU_W-1:0]  opnd_b,
  input logic [ALU_W-1:0]  acc_o,
  input logic [4:0]        flags_o,
  input logic [PAIR_W-1:0] pair_o
);

  logic is_grp;
  assign is_grp = op_en && (op_kind == 3'd0);

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !op_en |=> $stable(acc_o) && $stable(flags_o) && $stable(pair_o)); // R13

  AST_ZERO_TRACKS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (is_grp && op_field != 3'd7) |=> flags_o[3] == (acc_o == '0)); // R3

  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (is_grp && op_field == 3'd7) |=> $stable(acc_o)); // R5

  AST_AND_CLEARS_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (is_grp && op_field == 3'd4) |=> !flags_o[0]); // R6

  AST_OR_XOR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (is_grp && (op_field == 3'd5 || op_field == 3'd6)) |=> !flags_o[0] && !flags_o[2]); // R7

  AST_INCDEC_KEEP_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && (op_kind == 3'd1 || op_kind == 3'd2)) |=> $stable(flags_o[0])); // R8

  AST_CPLA_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_kind == 3'd3) |=> $stable(flags_o) && acc_o == ~$past(acc_o)); // R9

  AST_CPLC_ONLY_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_kind == 3'd4) |=> flags_o[0] != $past(flags_o[0])
                                   && $stable(flags_o[4:1]) && $stable(acc_o)); // R9

  AST_WIDE_ONLY_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_kind == 3'd6) |=> $stable(flags_o[4:1]) && $stable(acc_o)); // R11

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
    (op_en && op_kind == 3'd7) |=> acc_o == $past(opnd_b) && $stable(flags_o)); // R12

endmodule

bind accum_alu accum_alu_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_en    (op_en),
  .op_kind  (op_kind),
  .op_field (op_field),
  .opnd_b   (opnd_b),
  .acc_o    (acc_o),
  .flags_o  (flags_o),
  .pair_o   (pair_o)
);

// File: tb/accum_alu_tb.sv
module accum_alu_tb;

  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 4000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_en;
  logic [2:0]  op_kind;
  logic [2:0]  op_field;
  logic [7:0]  opnd_b;
  logic [15:0] pair_a;
  logic [15:0] pair_b;
  logic [7:0]  acc_o;
  logic [4:0]  flags_o;
  logic [15:0] pair_o;

  int n_checks = 0;
  int n_fail   = 0;

  logic [7:0]  m_acc;
  logic [4:0]  m_flags;
  logic [15:0] m_pair;

  accum_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op_kind(op_kind),
    .op_field(op_field), .opnd_b(opnd_b), .pair_a(pair_a), .pair_b(pair_b),
    .acc_o(acc_o), .flags_o(flags_o), .pair_o(pair_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R13: run hung, actual=expired expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  function automatic bit even_bits(int v);
    int cnt = 0;
    for (int i = 0; i < 8; i++) cnt += (v >> i) & 1;
    return (cnt % 2) == 0;
  endfunction

  function automatic logic [4:0] mk_flags(int r, bit ac, bit cy);
    return {r[7], (r == 0), ac, even_bits(r), cy};
  endfunction

  function automatic string tag_of(bit en, int kind, int field);
    if (!en) return "R13";
    case (kind)
      0: case (field)
           4: return "R6";
           5, 6: return "R7";
           7: return "R5";
           default: return "R4";
         endcase
      1, 2: return "R8";
      3, 4: return "R9";
      5: return "R10";
      6: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic model(bit en, int kind, int field, int b, int pa, int pb);
    int a  = m_acc;
    int cy = m_flags[0];
    int ac = m_flags[2];
    int r;
    int ci;
    if (!en) return;
    case (kind)
      0: begin
        if (field <= 1) begin
          ci = (field == 1) ? cy : 0;
          r = a + b + ci;
          m_acc = r[7:0];
          m_flags = mk_flags(r & 255, ((a & 15) + (b & 15) + ci) > 15, r > 255);
        end else if (field <= 3 || field == 7) begin
          ci = (field == 3) ? cy : 0;
          r = a - b - ci;
          m_flags = mk_flags(r & 255, ((a & 15) - (b & 15) - ci) < 0, r < 0);
          if (field != 7) m_acc = r[7:0];
        end else begin
          if (field == 4) r = a & b;
          else if (field == 5) r = a ^ b;
          else r = a | b;
          m_acc = r[7:0];
          m_flags = mk_flags(r, (field == 4) ? (((a | b) >> 3) & 1) : 0, 0);
        end
      end
      1: begin
        r = (a + 1) & 255;
        m_acc = r[7:0];
        m_flags = mk_flags(r, (a & 15) == 15, cy);
      end
      2: begin
        r = (a + 255) & 255;
        m_acc = r[7:0];
        m_flags = mk_flags(r, (a & 15) == 0, cy);
      end
      3: m_acc = ~m_acc;
      4: m_flags[0] = ~m_flags[0];
      5: begin
        bit lo, hi, nac;
        int t;
        lo  = ((a & 15) > 9) || (ac != 0);
        t   = a + (lo ? 6 : 0);
        nac = lo && (((a & 15) + 6) > 15);
        hi  = (cy != 0) || (t > 255) || (((t >> 4) & 15) > 9);
        r   = (t + (hi ? 96 : 0)) & 255;
        m_acc = r[7:0];
        m_flags = mk_flags(r, nac, hi);
      end
      6: begin
        r = pa + pb;
        m_pair = r[15:0];
        m_flags[0] = r[16];
      end
      default: m_acc = b[7:0];
    endcase
  endtask

  task automatic check(bit ok, string tag, logic [28:0] act, logic [28:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual acc/flags/pair=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, compare.
  task automatic step(bit en, int kind, int field, int b, int pa, int pb);
    op_en    = en;
    op_kind  = kind[2:0];
    op_field = field[2:0];
    opnd_b   = b[7:0];
    pair_a   = pa[15:0];
    pair_b   = pb[15:0];
    model(en, kind, field, b, pa, pb);
    @(negedge clk);
    check({acc_o, flags_o, pair_o} === {m_acc, m_flags, m_pair}, tag_of(en, kind, field),
          {acc_o, flags_o, pair_o}, {m_acc, m_flags, m_pair});
  endtask

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; op_en = 1'b0; op_kind = '0; op_field = '0;
    opnd_b = '0; pair_a = '0; pair_b = '0;
    m_acc = '0; m_flags = '0; m_pair = '0;
    repeat (3) @(negedge clk);
    check({acc_o, flags_o, pair_o} === 29'd0, "R1", {acc_o, flags_o, pair_o}, 29'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check({acc_o, flags_o, pair_o} === 29'd0, "R1", {acc_o, flags_o, pair_o}, 29'd0);

    // R2 R10: BCD 15 + 27 -> 42
    step(1, 7, 0, 8'h15, 0, 0);
    step(1, 0, 0, 8'h27, 0, 0);
    step(1, 5, 0, 0, 0, 0);
    check(acc_o === 8'h42, "R10", {21'd0, acc_o}, {21'd0, 8'h42});
    // R10: 99 + 01 -> 00 with decimal carry
    step(1, 7, 0, 8'h99, 0, 0);
    step(1, 0, 0, 8'h01, 0, 0);
    step(1, 5, 0, 0, 0, 0);
    check({acc_o, flags_o[0], flags_o[3]} === {8'h00, 1'b1, 1'b1}, "R10",
          {19'd0, acc_o, flags_o[0], flags_o[3]}, {19'd0, 8'h00, 2'b11});
    // R5: equal compare sets Z, keeps accumulator
    step(1, 7, 0, 8'h40, 0, 0);
    step(1, 0, 7, 8'h40, 0, 0);
    check(flags_o === 5'b01010 && acc_o === 8'h40, "R5",
          {16'd0, acc_o, flags_o}, {16'd0, 8'h40, 5'b01010});
    // R4: borrow through both nibbles with incoming borrow
    step(1, 4, 0, 0, 0, 0);
    step(1, 0, 3, 8'h00, 0, 0);
    step(1, 0, 1, 8'hFF, 0, 0);
    // R8: carry survives increment past FF and decrement past 00
    step(1, 7, 0, 8'hFF, 0, 0);
    step(1, 1, 0, 0, 0, 0);
    step(1, 2, 0, 0, 0, 0);
    // R11: pair add wrap
    step(1, 6, 0, 0, 16'hFFFF, 16'h0002);
    step(1, 6, 0, 0, 16'h1234, 16'h0100);
    // R3: parity on odd-count byte
    step(1, 7, 0, 8'h07, 0, 0);
    step(1, 0, 6, 8'h00, 0, 0);
    // R13: idle with noise
    step(0, 0, 0, 8'hAA, 16'hFFFF, 16'hFFFF);
    step(0, 7, 0, 8'h55, 0, 0);

    for (int i = 0; i < N_RANDOM; i++) begin
      bit en = ($urandom % 8) != 0;
      step(en, $urandom % 8, $urandom % 8, $urandom % 256,
           $urandom % 65536, $urandom % 65536);
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule